// File: doc/BRIEF.md
# Operand Fetch and Effective Address Unit

This block sits between an instruction decoder and a byte-wide memory port. When the decoder has read an opcode and knows its addressing mode, it hands the unit three things: a mode code, the current program counter and the two index registers. The unit then reads the operand bytes that follow at the program counter, advancing the counter by one for each byte. For the indirect modes it also reads a two-byte pointer. When it finishes, it presents the 16-bit effective address and the advanced program counter together with a one-cycle `done` pulse.

The memory port is a single read channel with a request/acknowledge handshake. The unit raises `bus_req` with an address and holds both until `bus_ack` returns, and it takes `bus_rdata` on the acknowledged edge. At most one read completes per cycle, and the responder may insert any number of wait cycles. The unit does not model page-crossing penalties and does not perform the final data access.

The control is a six-state machine:
- `ST_IDLE` waits for `start`.
- `ST_OPLO` reads the first operand byte.
- `ST_OPHI` reads the second operand byte (absolute-class modes).
- `ST_PTRLO` and `ST_PTRHI` read the pointer (indirect modes).
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

The transitions are:
- idle to done, for immediate and unused codes;
- idle to oplo, for every other mode;
- oplo to ophi, for absolute, absolute-indexed and absolute-indirect;
- oplo to ptrlo, for the two zero-page indirect forms;
- oplo to done, for zero-page and relative;
- ophi to ptrlo, for absolute-indirect;
- ophi to done, otherwise;
- ptrlo to ptrhi to done, each on an acknowledge;
- done to idle, unconditionally.

Top module: `operand_ea_unit`

## Requirements
- R1: Each operand byte read from the PC advances `pc_out` by one, wrapping from 16'hFFFF to 16'h0000. Pointer reads leave the PC unchanged.
- R2: Immediate (code 0) performs no bus read. `ea` is the PC given at start, `pc_out` is that PC plus one, and `done` is seen one cycle after `start` is sampled.
- R3: Absolute (code 4) reads the low byte at PC and then the high byte at PC+1. Absolute+X (5) and absolute+Y (6) add the zero-extended index to that address, wrapping at 16 bits.
- R4: Zero-page (1), zero-page+X (2) and zero-page+Y (3) read one byte. `ea` has a high byte of zero and a low byte of operand plus index modulo 256.
- R5: Zero-page X-indirect (8) reads the pointer low byte at (operand+X) mod 256 and the high byte at (operand+X+1) mod 256. `ea` is the pointer.
- R6: Zero-page indirect Y (9) reads the pointer at operand and (operand+1) mod 256, both in page zero. `ea` is the pointer plus zero-extended Y, wrapping at 16 bits.
- R7: Absolute indirect (7) reads the pointer low byte at the absolute operand and the high byte at that address plus one with a 16-bit carry. `ea` is the pointer.
- R8: Relative (10) reads one byte. `ea` is the PC after that byte plus the sign-extended byte, wrapping at 16 bits.
- R9: `bus_req` and `bus_addr` hold steady until `bus_ack`, and the byte is taken on the acknowledged edge. Each read costs one cycle plus its wait cycles, so a run with r reads and w waits per read ends r*(w+1)+1 cycles after start.
- R10: `done` is high for exactly one cycle, with `ea` and `pc_out` valid. After reset, `done`, `bus_req` and `busy` are low and `pc_out` is zero.
- R11: `start`, the mode code, `pc_in` and the index inputs are ignored while `busy` is high. Mode, PC and indices are captured when the operation starts.
- R12: Unused codes 11 to 15 perform no read and give `done` one cycle after start. Both `ea` and `pc_out` equal the PC given at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operand fetch (sampled in idle) |
| mode | input | 4 | Addressing-mode code (0 to 10 defined) |
| pc_in | input | 16 | PC pointing at the first operand byte |
| x_in | input | 8 | X index register value |
| y_in | input | 8 | Y index register value |
| busy | output | 1 | Unit is not idle |
| bus_req | output | 1 | Read request |
| bus_addr | output | 16 | Read address |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Read acknowledge |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address, valid with done |
| pc_out | output | 16 | PC after the consumed operand bytes |

## Verification
A wrong state or a wrong byte register surfaces at the ports within one operation:
- A wrong transition shows as an extra or missing bus read.
- A wrong pointer address shows as an unexpected `bus_addr` on the following read.
- A miscaptured byte or a wrong wrap boundary shows as a wrong `ea` at the `done` pulse, which comes at most a few cycles later.

A stuck machine shows at once as `done` never rising, or `done` lasting two cycles. A PC that steps on pointer reads appears in `pc_out` at the same pulse. Wait states on the bus show whether the byte registers capture only on an acknowledged edge.

// File: rtl/oea_pkg.sv
package oea_pkg;

    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_ZP   = 4'd1,
        AM_ZPX  = 4'd2,
        AM_ZPY  = 4'd3,
        AM_ABS  = 4'd4,
        AM_ABSX = 4'd5,
        AM_ABSY = 4'd6,
        AM_IND  = 4'd7,
        AM_IZX  = 4'd8,
        AM_IZY  = 4'd9,
        AM_REL  = 4'd10
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPLO,
        ST_OPHI,
        ST_PTRLO,
        ST_PTRHI,
        ST_DONE
    } fstate_e;

    localparam int MODE_W = 4;

    function automatic logic am_known(input logic [MODE_W-1:0] m);
        return m <= AM_REL;
    endfunction

    function automatic logic am_two_byte(input logic [MODE_W-1:0] m);
        return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_IND);
    endfunction

    function automatic logic am_zp_ptr(input logic [MODE_W-1:0] m);
        return (m == AM_IZX) || (m == AM_IZY);
    endfunction

    function automatic logic am_zero_page(input logic [MODE_W-1:0] m);
        return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
    endfunction

endpackage

// File: rtl/oea_fsm.sv
module oea_fsm
    import oea_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic [MODE_W-1:0]   mode_q,
    input  logic                bus_ack,
    output fstate_e             state,
    output logic                bus_req,
    output logic                done,
    output logic                busy
);

    fstate_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if ((mode_in == AM_IMM) || !am_known(mode_in)) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt = ST_OPLO;
                    end
                end
            end
            ST_OPLO: begin
                if (bus_ack) begin
                    if (am_two_byte(mode_q)) begin
                        nxt = ST_OPHI;
                    end else if (am_zp_ptr(mode_q)) begin
                        nxt = ST_PTRLO;
                    end else begin
                        nxt = ST_DONE;
                    end
                end
            end
            ST_OPHI: begin
                if (bus_ack) begin
                    nxt = (mode_q == AM_IND) ? ST_PTRLO : ST_DONE;
                end
            end
            ST_PTRLO: begin
                if (bus_ack) begin
                    nxt = ST_PTRHI;
                end
            end
            ST_PTRHI: begin
                if (bus_ack) begin
                    nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        bus_req = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:  busy    = 1'b0;
            ST_OPLO,
            ST_OPHI,
            ST_PTRLO,
            ST_PTRHI: bus_req = 1'b1;
            ST_DONE:  done    = 1'b1;
            default:  busy    = 1'b1;
        endcase
    end

endmodule

// File: rtl/oea_regs.sv
module oea_regs
    import oea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  fstate_e                 state,
    input  logic                    start,
    input  logic [MODE_W-1:0]       mode_in,
    input  logic [2*DATA_W-1:0]     pc_in,
    input  logic [DATA_W-1:0]       x_in,
    input  logic [DATA_W-1:0]       y_in,
    input  logic                    bus_ack,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic [MODE_W-1:0]       mode_q,
    output logic [2*DATA_W-1:0]     pc_q,
    output logic [2*DATA_W-1:0]     base_pc,
    output logic [DATA_W-1:0]       x_q,
    output logic [DATA_W-1:0]       y_q,
    output logic [DATA_W-1:0]       op_lo,
    output logic [DATA_W-1:0]       op_hi,
    output logic [DATA_W-1:0]       ptr_lo,
    output logic [DATA_W-1:0]       ptr_hi
);

    localparam int ADDR_W = 2 * DATA_W;

    logic accept;
    assign accept = (state == ST_IDLE) && start;

    // Captured operation context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            base_pc <= '0;
            x_q     <= '0;
            y_q     <= '0;
        end else if (accept) begin
            mode_q  <= mode_in;
            base_pc <= pc_in;
            x_q     <= x_in;
            y_q     <= y_in;
        end
    end

    // Program counter: loaded on accept, stepped on each operand byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (accept) begin
            pc_q <= (mode_in == AM_IMM) ? pc_in + ADDR_W'(1) : pc_in;
        end else if (bus_ack && ((state == ST_OPLO) || (state == ST_OPHI))) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    // Byte capture on acknowledged reads.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_lo  <= '0;
            op_hi  <= '0;
            ptr_lo <= '0;
            ptr_hi <= '0;
        end else if (bus_ack) begin
            case (state)
                ST_OPLO:  op_lo  <= bus_rdata;
                ST_OPHI:  op_hi  <= bus_rdata;
                ST_PTRLO: ptr_lo <= bus_rdata;
                ST_PTRHI: ptr_hi <= bus_rdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/oea_addr.sv
module oea_addr
    import oea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [MODE_W-1:0]       mode_q,
    input  logic [2*DATA_W-1:0]     pc_q,
    input  logic [2*DATA_W-1:0]     base_pc,
    input  logic [DATA_W-1:0]       x_q,
    input  logic [DATA_W-1:0]       y_q,
    input  logic [DATA_W-1:0]       op_lo,
    input  logic [DATA_W-1:0]       op_hi,
    input  logic [DATA_W-1:0]       ptr_lo,
    input  logic [DATA_W-1:0]       ptr_hi,
    output logic [2*DATA_W-1:0]     ptr_lo_addr,
    output logic [2*DATA_W-1:0]     ptr_hi_addr,
    output logic [2*DATA_W-1:0]     ea
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] PAGE0 = '0;

    logic [DATA_W-1:0] zp_x, zp_y, zp_x_nx, zp_nx;
    logic [ADDR_W-1:0] abs_a, ptr_a, x_ext, y_ext, rel_off;

    always_comb begin
        zp_x    = op_lo + x_q;
        zp_y    = op_lo + y_q;
        zp_x_nx = zp_x + DATA_W'(1);
        zp_nx   = op_lo + DATA_W'(1);
        abs_a   = {op_hi, op_lo};
        ptr_a   = {ptr_hi, ptr_lo};
        x_ext   = {PAGE0, x_q};
        y_ext   = {PAGE0, y_q};
        rel_off = {{DATA_W{op_lo[DATA_W-1]}}, op_lo};
    end

    // Pointer fetch addresses for the indirect modes.
    always_comb begin
        ptr_lo_addr = abs_a;
        ptr_hi_addr = abs_a + ADDR_W'(1);
        unique case (mode_q)
            AM_IZX: begin
                ptr_lo_addr = {PAGE0, zp_x};
                ptr_hi_addr = {PAGE0, zp_x_nx};
            end
            AM_IZY: begin
                ptr_lo_addr = {PAGE0, op_lo};
                ptr_hi_addr = {PAGE0, zp_nx};
            end
            default: begin
                ptr_lo_addr = abs_a;
                ptr_hi_addr = abs_a + ADDR_W'(1);
            end
        endcase
    end

    // Final effective address.
    always_comb begin
        unique case (mode_q)
            AM_IMM:  ea = base_pc;
            AM_ZP:   ea = {PAGE0, op_lo};
            AM_ZPX:  ea = {PAGE0, zp_x};
            AM_ZPY:  ea = {PAGE0, zp_y};
            AM_ABS:  ea = abs_a;
            AM_ABSX: ea = abs_a + x_ext;
            AM_ABSY: ea = abs_a + y_ext;
            AM_IND:  ea = ptr_a;
            AM_IZX:  ea = ptr_a;
            AM_IZY:  ea = ptr_a + y_ext;
            AM_REL:  ea = pc_q + rel_off;
            default: ea = base_pc;
        endcase
    end

endmodule

// File: rtl/operand_ea_unit.sv
module operand_ea_unit
    import oea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [3:0]              mode,
    input  logic [2*DATA_W-1:0]     pc_in,
    input  logic [DATA_W-1:0]       x_in,
    input  logic [DATA_W-1:0]       y_in,
    output logic                    busy,
    output logic                    bus_req,
    output logic [2*DATA_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]       bus_rdata,
    input  logic                    bus_ack,
    output logic                    done,
    output logic [2*DATA_W-1:0]     ea,
    output logic [2*DATA_W-1:0]     pc_out
);

    localparam int ADDR_W = 2 * DATA_W;

    fstate_e             fsm_state;
    logic [MODE_W-1:0]   mode_q;
    logic [ADDR_W-1:0]   pc_q, base_pc, ptr_lo_addr, ptr_hi_addr;
    logic [DATA_W-1:0]   x_q, y_q, op_lo, op_hi, ptr_lo, ptr_hi;

    oea_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode),
        .mode_q  (mode_q),
        .bus_ack (bus_ack),
        .state   (fsm_state),
        .bus_req (bus_req),
        .done    (done),
        .busy    (busy)
    );

    oea_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (fsm_state),
        .start     (start),
        .mode_in   (mode),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .mode_q    (mode_q),
        .pc_q      (pc_q),
        .base_pc   (base_pc),
        .x_q       (x_q),
        .y_q       (y_q),
        .op_lo     (op_lo),
        .op_hi     (op_hi),
        .ptr_lo    (ptr_lo),
        .ptr_hi    (ptr_hi)
    );

    oea_addr #(.DATA_W(DATA_W)) u_addr (
        .mode_q      (mode_q),
        .pc_q        (pc_q),
        .base_pc     (base_pc),
        .x_q         (x_q),
        .y_q         (y_q),
        .op_lo       (op_lo),
        .op_hi       (op_hi),
        .ptr_lo      (ptr_lo),
        .ptr_hi      (ptr_hi),
        .ptr_lo_addr (ptr_lo_addr),
        .ptr_hi_addr (ptr_hi_addr),
        .ea          (ea)
    );

    always_comb begin
        unique case (fsm_state)
            ST_PTRLO: bus_addr = ptr_lo_addr;
            ST_PTRHI: bus_addr = ptr_hi_addr;
            default:  bus_addr = pc_q;
        endcase
    end

    assign pc_out = pc_q;

endmodule

// File: rtl/oea_chk.sv
module oea_chk
    import oea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] pc_out,
    input logic [ADDR_W-1:0] ea,
    input fstate_e           state,
    input logic [3:0]        mode_q
);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_req_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    assert_pc_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_OPLO) || (state == ST_OPHI)) && bus_ack)
            |=> (pc_out == $past(pc_out) + ADDR_W'(1)));

    assert_pc_still_on_pointer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_PTRLO) || (state == ST_PTRHI)) && bus_ack) |=> $stable(pc_out));

    assert_zero_page_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && am_zero_page(mode_q)) |-> (ea[ADDR_W-1:ADDR_W/2] == '0));

    assert_imm_consumes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_IMM)) |-> (pc_out == ea + ADDR_W'(1)));

    assert_unused_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q > AM_REL)) |-> (pc_out == ea));

endmodule

bind operand_ea_unit oea_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .pc_out   (pc_out),
    .ea       (ea),
    .state    (fsm_state),
    .mode_q   (mode_q)
);

// File: tb/operand_ea_unit_tb.sv
module operand_ea_unit_tb;
    import oea_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  x_in = 8'h0, y_in = 8'h0;
    logic        busy, bus_req, done;
    logic [15:0] bus_addr, ea, pc_out;
    logic [7:0]  bus_rdata = 8'h0;
    logic        bus_ack = 1'b0;

    operand_ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .busy(busy), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .done(done), .ea(ea), .pc_out(pc_out)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Sparse memory: hashed default plus a few override slots.
    logic [15:0] ov_a [8];
    logic [7:0]  ov_d [8];
    logic        ov_v [8];

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        logic [7:0] d;
        d = (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
        for (int i = 0; i < 8; i++) if (ov_v[i] && ov_a[i] == a) d = ov_d[i];
        return d;
    endfunction

    task automatic clear_ov();
        for (int i = 0; i < 8; i++) begin ov_v[i] = 1'b0; ov_a[i] = '0; ov_d[i] = '0; end
    endtask

    task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
        ov_a[i] = a; ov_d[i] = d; ov_v[i] = 1'b1;
    endtask

    // Bus responder: drives 2 ns after each rising edge.
    int          wait_n = 0;
    int          wait_cnt = 0;
    int          n_reads = 0;
    logic [15:0] rd_log [8];

    always begin
        @(posedge clk);
        #2;
        bus_ack = 1'b0;
        if (rst_n && bus_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                bus_ack   = 1'b1;
                bus_rdata = mem_rd(bus_addr);
                rd_log[n_reads % 8] = bus_addr;
                n_reads++;
                wait_cnt = wait_n;
            end
        end else begin
            wait_cnt = wait_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            AM_IMM:                 return "R2";
            AM_ZP, AM_ZPX, AM_ZPY:  return "R4";
            AM_ABS, AM_ABSX, AM_ABSY: return "R3";
            AM_IND:                 return "R7";
            AM_IZX:                 return "R5";
            AM_IZY:                 return "R6";
            AM_REL:                 return "R8";
            default:                return "R12";
        endcase
    endfunction

    // Reference model from the requirements.
    task automatic ref_ea(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x,
                          input logic [7:0] y, output logic [15:0] e, output logic [15:0] pn);
        logic [7:0]  b0, b1, zp;
        logic [15:0] a;
        b0 = mem_rd(pc);
        b1 = mem_rd(pc + 16'd1);
        pn = pc + 16'd1;
        case (m)
            AM_IMM:  e = pc;
            AM_ZP:   e = {8'h00, b0};
            AM_ZPX:  begin zp = b0 + x; e = {8'h00, zp}; end
            AM_ZPY:  begin zp = b0 + y; e = {8'h00, zp}; end
            AM_ABS:  begin e = {b1, b0}; pn = pc + 16'd2; end
            AM_ABSX: begin e = {b1, b0} + {8'h00, x}; pn = pc + 16'd2; end
            AM_ABSY: begin e = {b1, b0} + {8'h00, y}; pn = pc + 16'd2; end
            AM_IND:  begin a = {b1, b0}; e = {mem_rd(a + 16'd1), mem_rd(a)}; pn = pc + 16'd2; end
            AM_IZX:  begin zp = b0 + x; e = {mem_rd({8'h00, zp + 8'd1}), mem_rd({8'h00, zp})}; end
            AM_IZY:  e = {mem_rd({8'h00, b0 + 8'd1}), mem_rd({8'h00, b0})} + {8'h00, y};
            AM_REL:  e = pn + {{8{b0[7]}}, b0};
            default: begin e = pc; pn = pc; end
        endcase
    endtask

    // One operation; checks the done pulse width (R10).
    task automatic run(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x,
                       input logic [7:0] y, input int wt, input bit poke,
                       output logic [15:0] got_ea, output logic [15:0] got_pc,
                       output int cyc, output int reads, output int base);
        wait_n = wt;
        base = n_reads;
        @(negedge clk);
        start = 1'b1; mode = m; pc_in = pc; x_in = x; y_in = y;
        @(negedge clk);
        cyc = 1;
        start = 1'b0; mode = 4'd0; pc_in = 16'hDEAD; x_in = 8'h5C; y_in = 8'hC5;
        while (!done && cyc < 60) begin
            if (poke && cyc == 2) begin
                start = 1'b1; mode = AM_ABS; pc_in = 16'h7777;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R10 done seen", {31'd0, done}, 32'd1);
        got_ea = ea;
        got_pc = pc_out;
        reads  = n_reads - base;
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    typedef struct packed {
        logic [3:0]  m;
        logic [15:0] pc;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [1:0]  wt;
        logic [1:0]  len;
        logic [2:0]  nr;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{AM_IMM,  16'h1234, 8'h00, 8'h00, 2'd0, 2'd1, 3'd0},
        '{AM_ZP,   16'h2000, 8'h00, 8'h00, 2'd1, 2'd1, 3'd1},
        '{AM_ZPX,  16'h2100, 8'h33, 8'h00, 2'd0, 2'd1, 3'd1},
        '{AM_ZPY,  16'h2200, 8'h00, 8'h7F, 2'd2, 2'd1, 3'd1},
        '{AM_ABS,  16'h2300, 8'h00, 8'h00, 2'd0, 2'd2, 3'd2},
        '{AM_ABSX, 16'h2400, 8'hC8, 8'h00, 2'd1, 2'd2, 3'd2},
        '{AM_ABSY, 16'h2500, 8'h00, 8'hFF, 2'd0, 2'd2, 3'd2},
        '{AM_IND,  16'h2600, 8'h00, 8'h00, 2'd1, 2'd2, 3'd4},
        '{AM_IZX,  16'h2700, 8'h9A, 8'h00, 2'd0, 2'd1, 3'd3},
        '{AM_IZY,  16'h2800, 8'h00, 8'h44, 2'd2, 2'd1, 3'd3},
        '{AM_REL,  16'h2900, 8'h00, 8'h00, 2'd0, 2'd1, 3'd1},
        '{AM_REL,  16'hA0F0, 8'h00, 8'h00, 2'd1, 2'd1, 3'd1}
    };

    task automatic directed(input string req, input logic [3:0] m, input logic [15:0] pc,
                            input logic [7:0] x, input logic [7:0] y,
                            input logic [15:0] exp_ea, input logic [15:0] exp_pc,
                            output int base);
        logic [15:0] ge, gp;
        int c, r;
        run(m, pc, x, y, 0, 1'b0, ge, gp, c, r, base);
        chk({req, " ea"}, {16'd0, ge}, {16'd0, exp_ea});
        chk({req, " pc"}, {16'd0, gp}, {16'd0, exp_pc});
    endtask

    initial begin : main
        logic [15:0] ge, gp, ee, ep;
        int c, r, b;
        clear_ov();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset done", {31'd0, done}, 32'd0);
        chk("R10 reset bus_req", {31'd0, bus_req}, 32'd0);
        chk("R10 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset pc_out", {16'd0, pc_out}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            run(VECS[i].m, VECS[i].pc, VECS[i].x, VECS[i].y, int'(VECS[i].wt), 1'b0, ge, gp, c, r, b);
            ref_ea(VECS[i].m, VECS[i].pc, VECS[i].x, VECS[i].y, ee, ep);
            chk({req_of(VECS[i].m), " ea"}, {16'd0, ge}, {16'd0, ee});
            chk("R1 pc advance", {16'd0, gp}, {16'd0, VECS[i].pc + 16'(VECS[i].len)});
            chk("R1 pc ref", {16'd0, gp}, {16'd0, ep});
            chk("R9 read count", r, int'(VECS[i].nr));
            chk("R9 cycle count", c, int'(VECS[i].nr) * (int'(VECS[i].wt) + 1) + 1);
        end

        // R4: zero-page index wraps inside page zero
        clear_ov(); set_ov(0, 16'h0300, 8'hF0);
        directed("R4 zpx wrap", AM_ZPX, 16'h0300, 8'h20, 8'h00, 16'h0010, 16'h0301, b);

        // R3: absolute index wraps at 16 bits
        clear_ov(); set_ov(0, 16'h0400, 8'hF0); set_ov(1, 16'h0401, 8'hFF);
        directed("R3 absx wrap", AM_ABSX, 16'h0400, 8'h20, 8'h00, 16'h0010, 16'h0402, b);

        // R1: PC wraps while fetching operand bytes
        clear_ov(); set_ov(0, 16'hFFFF, 8'h34); set_ov(1, 16'h0000, 8'h12);
        directed("R1 pc wrap", AM_ABS, 16'hFFFF, 8'h00, 8'h00, 16'h1234, 16'h0001, b);
        chk("R1 second byte address", {16'd0, rd_log[(b + 1) % 8]}, 32'h0000);

        // R5: pointer high byte stays in page zero
        clear_ov(); set_ov(0, 16'h0500, 8'hFF); set_ov(1, 16'h00FF, 8'hCD); set_ov(2, 16'h0000, 8'hAB);
        directed("R5 izx wrap", AM_IZX, 16'h0500, 8'h00, 8'h00, 16'hABCD, 16'h0501, b);
        chk("R5 ptr lo addr", {16'd0, rd_log[(b + 1) % 8]}, 32'h00FF);
        chk("R5 ptr hi addr", {16'd0, rd_log[(b + 2) % 8]}, 32'h0000);

        // R5: X added before the pointer read
        clear_ov(); set_ov(0, 16'h0580, 8'h10); set_ov(1, 16'h0015, 8'h22); set_ov(2, 16'h0016, 8'h33);
        directed("R5 izx index", AM_IZX, 16'h0580, 8'h05, 8'h00, 16'h3322, 16'h0581, b);

        // R6: Y added after the pointer read, with 16-bit carry and wrap
        clear_ov(); set_ov(0, 16'h0600, 8'h40); set_ov(1, 16'h0040, 8'hF0); set_ov(2, 16'h0041, 8'hFF);
        directed("R6 izy wrap", AM_IZY, 16'h0600, 8'h00, 8'h20, 16'h0010, 16'h0601, b);

        // R7: pointer high byte carries into next page
        clear_ov(); set_ov(0, 16'h0700, 8'hFF); set_ov(1, 16'h0701, 8'h10);
        set_ov(2, 16'h10FF, 8'h78); set_ov(3, 16'h1100, 8'h56);
        directed("R7 ind page carry", AM_IND, 16'h0700, 8'h00, 8'h00, 16'h5678, 16'h0702, b);
        chk("R7 ptr hi addr", {16'd0, rd_log[(b + 3) % 8]}, 32'h1100);

        // R8: negative and wrapping relative offsets
        clear_ov(); set_ov(0, 16'h0800, 8'h80);
        directed("R8 rel negative", AM_REL, 16'h0800, 8'h00, 8'h00, 16'h0781, 16'h0801, b);
        clear_ov(); set_ov(0, 16'hFFFE, 8'h05);
        directed("R8 rel wrap", AM_REL, 16'hFFFE, 8'h00, 8'h00, 16'h0004, 16'hFFFF, b);

        // R12: unused code
        clear_ov();
        run(4'd13, 16'h0900, 8'h00, 8'h00, 0, 1'b0, ge, gp, c, r, b);
        chk("R12 ea", {16'd0, ge}, 32'h0900);
        chk("R12 pc", {16'd0, gp}, 32'h0900);
        chk("R12 no reads", r, 0);
        chk("R12 cycles", c, 1);

        // R11: start and inputs during a busy fetch are ignored
        clear_ov(); set_ov(0, 16'h0A00, 8'h60); set_ov(1, 16'h0060, 8'h00); set_ov(2, 16'h0061, 8'h30);
        run(AM_IZY, 16'h0A00, 8'h00, 8'h0C, 2, 1'b1, ge, gp, c, r, b);
        chk("R11 ea", {16'd0, ge}, 32'h300C);
        chk("R11 pc", {16'd0, gp}, 32'h0A01);
        chk("R11 reads", r, 3);
        @(negedge clk);
        chk("R11 back to idle", {31'd0, busy}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule